// File: doc/BRIEF.md
# Modulo-Scheduled Lookup Issue Controller

This controller admits lookup requests into a pool of in-order processing contexts that all share a single memory port. There is no arbiter on that port. Every lookup runs the same fixed-length schedule and touches memory at a small set of configured cycle offsets. Admissions happen only on cycles that are a multiple of the access count m. Each access offset is also required to have its own residue modulo m. Together these two rules mean that two lookups in flight can never want the memory in the same cycle.

The block applies backpressure to the request interface so that admissions stay at one per m cycles. It assigns contexts in round-robin order and tells the memory which context owns the port in each cycle. It also marks each lookup's final cycle. A combinational checker rejects any schedule that breaks the rules, and admission stays blocked while the schedule is invalid. Instruction execution itself is modelled only as a per-context elapsed-cycle counter. The schedule inputs are treated as static while lookups are in flight.

Top module: `lookup_issue_ctrl`

## Requirements
- R1: During reset and before its synchronous release, `req_ready`, `mem_grant` and `done_valid` are low.
- R2: Cycle t counts from 0, the first cycle after the internal reset release. `req_ready` can be high only on cycles with t mod m = 0, where m is `cfg_acc_cnt`. A request is accepted in a cycle where `req_valid` and `req_ready` are both high.
- R3: Contexts are handed out round-robin. The k-th accepted request (k from 0) runs in context k mod 32, and that index is reported on `mem_slot` and `done_slot`.
- R4: Access field i is `cfg_acc_pos[i*8 +: 8]`, and it is active when i < m. A request accepted in cycle c is granted the memory in cycle c+1+p for each active field value p. In that cycle `mem_grant` is high and `mem_slot`/`mem_tag` carry its context and tag. In all other cycles `mem_grant` is low.
- R5: Every lookup lasts exactly L = `cfg_sched_len` cycles. A request accepted in cycle c raises `done_valid` in cycle c+L, with its context and tag on `done_slot`/`done_tag`.
- R6: Under a valid schedule, at most one context asks for the memory in any cycle, and at most one context is in its final cycle.
- R7: `cfg_err` is high exactly when any of these holds: m is 0 or greater than 4; L is 0 or greater than 32·m; an active field is at least L; two active fields have the same value modulo m. Inactive fields have no effect.
- R8: While `cfg_err` is high, `req_ready` stays low and no request is accepted.
- R9: A context becomes free again during its final cycle. As a result, with `req_valid` held high, a schedule of length 32·m still admits a request on every cycle with t mod m = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_acc_cnt | input | 3 | Number of memory accesses per lookup (m) |
| cfg_acc_pos | input | 32 | Four 8-bit access offsets; field i at bits [i*8 +: 8] |
| cfg_sched_len | input | 8 | Lookup length L in cycles |
| cfg_err | output | 1 | Schedule violates the conflict-free rules |
| req_valid | input | 1 | Lookup request present |
| req_tag | input | 8 | Request identifier carried with the lookup |
| req_ready | output | 1 | Request accepted this cycle if valid |
| mem_grant | output | 1 | Memory port used this cycle |
| mem_slot | output | 5 | Context that owns the memory port |
| mem_tag | output | 8 | Tag of the lookup owning the memory port |
| done_valid | output | 1 | A lookup is in its final cycle |
| done_slot | output | 5 | Context finishing |
| done_tag | output | 8 | Tag of the lookup finishing |

## Verification
The schedule 0, 2, 7 with m = 3 is run with requests held high and then with sparse requests. The full stream shows that interleaved lookups never collide, and the sparse stream shows that gaps do not shift later grants off the m-cycle grid. Full-length schedules (L = 32·m, including m = 1) show whether a context is recycled in its last cycle or one cycle too late, which the admission count exposes. Directed invalid schedules cover each error condition, plus one case where an inactive field would clash if it were active. Random legal and illegal schedules then compare every grant, completion and ready cycle against a model of admission times.

// File: rtl/mlic_pkg.sv
package mlic_pkg;

  // Per-context status as seen by the controller
  typedef struct packed {
    logic busy;
    logic last;
    logic hit;
  } ctx_stat_t;

endpackage

// File: rtl/mlic_phase.sv
// Admission phase counter: counts 0..m-1 repeatedly; admission window at 0.
module mlic_phase #(
  parameter int M_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] acc_cnt,
  output logic           phase_zero
);

  logic [M_W-1:0] phase_q;
  logic [M_W-1:0] phase_d;
  logic [M_W:0]   phase_inc;

  always_comb begin
    phase_inc = {1'b0, phase_q} + 1'b1;
    if (phase_inc >= {1'b0, acc_cnt}) begin
      phase_d = '0;
    end else begin
      phase_d = phase_inc[M_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase_zero = (phase_q == '0);

endmodule

// File: rtl/mlic_cfg_check.sv
// Combinational legality check of the access schedule.
module mlic_cfg_check #(
  parameter int NUM_SLOTS = 32,
  parameter int MAX_ACC   = 4,
  parameter int POS_W     = 8,
  parameter int M_W       = 3
) (
  input  logic [M_W-1:0]           acc_cnt,
  input  logic [MAX_ACC*POS_W-1:0] acc_pos,
  input  logic [POS_W-1:0]         sched_len,
  output logic                     cfg_ok
);

  localparam int LIM_W = POS_W + M_W + 1;

  logic [POS_W-1:0] pos_a [MAX_ACC];
  // res_a[k-1][i] = field i modulo k, constant divisor per row
  logic [POS_W-1:0] res_a [MAX_ACC][MAX_ACC];
  logic [LIM_W-1:0] len_lim;
  logic             cnt_bad;
  logic             len_bad;
  logic             range_bad;
  logic             dup_bad;

  for (genvar gi = 0; gi < MAX_ACC; gi++) begin : g_field
    assign pos_a[gi] = acc_pos[gi*POS_W +: POS_W];
    for (genvar gk = 1; gk <= MAX_ACC; gk++) begin : g_mod
      assign res_a[gk-1][gi] = pos_a[gi] % POS_W'(gk);
    end
  end

  assign len_lim = LIM_W'(acc_cnt) * LIM_W'(NUM_SLOTS);

  always_comb begin
    cnt_bad   = (acc_cnt == '0) || (int'(acc_cnt) > MAX_ACC);
    len_bad   = (sched_len == '0) || (LIM_W'(sched_len) > len_lim);
    range_bad = 1'b0;
    dup_bad   = 1'b0;
    for (int i = 0; i < MAX_ACC; i++) begin
      if (i < int'(acc_cnt) && pos_a[i] >= sched_len) begin
        range_bad = 1'b1;
      end
    end
    for (int i = 0; i < MAX_ACC; i++) begin
      for (int j = i + 1; j < MAX_ACC; j++) begin
        for (int k = 1; k <= MAX_ACC; k++) begin
          if (j < int'(acc_cnt) && int'(acc_cnt) == k &&
              res_a[k-1][i] == res_a[k-1][j]) begin
            dup_bad = 1'b1;
          end
        end
      end
    end
    cfg_ok = !(cnt_bad || len_bad || range_bad || dup_bad);
  end

endmodule

// File: rtl/mlic_ctx.sv
// One processing context: elapsed-cycle counter, busy flag and request tag.
module mlic_ctx
  import mlic_pkg::*;
#(
  parameter int MAX_ACC = 4,
  parameter int POS_W   = 8,
  parameter int M_W     = 3,
  parameter int TAG_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [TAG_W-1:0]         tag_in,
  input  logic [M_W-1:0]           acc_cnt,
  input  logic [MAX_ACC*POS_W-1:0] acc_pos,
  input  logic [POS_W-1:0]         sched_len,
  output ctx_stat_t                stat,
  output logic [TAG_W-1:0]         tag_out
);

  logic             busy_q, busy_d;
  logic [POS_W-1:0] cnt_q, cnt_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             clk_en;
  logic             last;
  logic             hit;

  always_comb begin
    last = busy_q && (cnt_q == sched_len - 1'b1);
    hit  = 1'b0;
    for (int i = 0; i < MAX_ACC; i++) begin
      if (i < int'(acc_cnt) && cnt_q == acc_pos[i*POS_W +: POS_W]) begin
        hit = busy_q;
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    tag_d  = tag_q;
    clk_en = start || busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      tag_d  = tag_in;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tag_q  <= '0;
    end else if (clk_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      tag_q  <= tag_d;
    end
  end

  assign stat.busy = busy_q;
  assign stat.last = last;
  assign stat.hit  = hit;
  assign tag_out   = tag_q;

endmodule

// File: rtl/mlic_pick.sv
// Lowest-index selector over a request vector.
module mlic_pick #(
  parameter int N  = 32,
  parameter int SW = 5
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [SW-1:0] idx
);

  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = SW'(i);
      end
    end
  end

endmodule

// File: rtl/lookup_issue_ctrl.sv
module lookup_issue_ctrl
  import mlic_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int MAX_ACC   = 4,
  parameter int TAG_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int M_W      = $clog2(MAX_ACC + 1),
  localparam int POS_W    = $clog2(NUM_SLOTS * MAX_ACC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [M_W-1:0]           cfg_acc_cnt,
  input  logic [MAX_ACC*POS_W-1:0] cfg_acc_pos,
  input  logic [POS_W-1:0]         cfg_sched_len,
  output logic                     cfg_err,
  input  logic                     req_valid,
  input  logic [TAG_W-1:0]         req_tag,
  output logic                     req_ready,
  output logic                     mem_grant,
  output logic [SLOT_W-1:0]        mem_slot,
  output logic [TAG_W-1:0]         mem_tag,
  output logic                     done_valid,
  output logic [SLOT_W-1:0]        done_slot,
  output logic [TAG_W-1:0]         done_tag
);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  logic                 phase_zero;
  logic                 cfg_ok;
  logic                 accept;
  logic [SLOT_W-1:0]    ptr_q, ptr_d;
  logic [NUM_SLOTS-1:0] start_vec;
  logic [NUM_SLOTS-1:0] hit_vec;
  logic [NUM_SLOTS-1:0] last_vec;
  logic [NUM_SLOTS-1:0] free_vec;
  logic [TAG_W-1:0]     tag_arr [NUM_SLOTS];

  mlic_phase #(.M_W(M_W)) i_phase (
    .clk        (clk),
    .rst_n      (rst_i),
    .acc_cnt    (cfg_acc_cnt),
    .phase_zero (phase_zero)
  );

  mlic_cfg_check #(
    .NUM_SLOTS (NUM_SLOTS),
    .MAX_ACC   (MAX_ACC),
    .POS_W     (POS_W),
    .M_W       (M_W)
  ) i_cfg (
    .acc_cnt   (cfg_acc_cnt),
    .acc_pos   (cfg_acc_pos),
    .sched_len (cfg_sched_len),
    .cfg_ok    (cfg_ok)
  );

  assign cfg_err   = !cfg_ok;
  assign req_ready = rst_i && phase_zero && cfg_ok && free_vec[ptr_q];
  assign accept    = req_valid && req_ready;

  // Round-robin context pointer
  always_comb begin
    if (ptr_q == SLOT_W'(NUM_SLOTS - 1)) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ptr_q <= '0;
    end else if (accept) begin
      ptr_q <= ptr_d;
    end
  end

  for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_ctx
    ctx_stat_t stat;

    assign start_vec[gs] = accept && (ptr_q == SLOT_W'(gs));

    mlic_ctx #(
      .MAX_ACC (MAX_ACC),
      .POS_W   (POS_W),
      .M_W     (M_W),
      .TAG_W   (TAG_W)
    ) i_ctx (
      .clk       (clk),
      .rst_n     (rst_i),
      .start     (start_vec[gs]),
      .tag_in    (req_tag),
      .acc_cnt   (cfg_acc_cnt),
      .acc_pos   (cfg_acc_pos),
      .sched_len (cfg_sched_len),
      .stat      (stat),
      .tag_out   (tag_arr[gs])
    );

    assign hit_vec[gs]  = stat.hit;
    assign last_vec[gs] = stat.last;
    assign free_vec[gs] = !stat.busy || stat.last;
  end

  mlic_pick #(.N(NUM_SLOTS), .SW(SLOT_W)) i_pick_mem (
    .req   (hit_vec),
    .valid (mem_grant),
    .idx   (mem_slot)
  );

  mlic_pick #(.N(NUM_SLOTS), .SW(SLOT_W)) i_pick_done (
    .req   (last_vec),
    .valid (done_valid),
    .idx   (done_slot)
  );

  assign mem_tag  = tag_arr[mem_slot];
  assign done_tag = tag_arr[done_slot];

endmodule

// File: rtl/lookup_issue_ctrl_chk.sv
module lookup_issue_ctrl_chk #(
  parameter int NUM_SLOTS = 32,
  parameter int M_W       = 3
) (
  input logic                 clk,
  input logic                 rst_i,
  input logic [M_W-1:0]       acc_cnt,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 cfg_err,
  input logic [NUM_SLOTS-1:0] hit_vec,
  input logic [NUM_SLOTS-1:0] last_vec
);

  logic        seen_q;
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else if (req_valid && req_ready) begin
      seen_q <= 1'b1;
      gap_q  <= 16'd1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q  <= gap_q + 16'd1;
    end
  end

  // R2
  accept_spacing_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && req_ready && seen_q && acc_cnt != '0) |->
      ((int'(gap_q) % int'(acc_cnt)) == 0));

  // R6
  single_mem_user_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_err |-> $onehot0(hit_vec));

  // R6
  single_finish_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(last_vec));

  // R8
  err_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_err |-> !req_ready);

endmodule

bind lookup_issue_ctrl lookup_issue_ctrl_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .M_W       (M_W)
) i_lookup_issue_ctrl_chk (
  .clk       (clk),
  .rst_i     (rst_i),
  .acc_cnt   (cfg_acc_cnt),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cfg_err   (cfg_err),
  .hit_vec   (hit_vec),
  .last_vec  (last_vec)
);

// File: tb/test_lookup_issue_ctrl.sv
module test_lookup_issue_ctrl;

  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_acc_cnt;
  logic [31:0] cfg_acc_pos;
  logic [7:0]  cfg_sched_len;
  logic        cfg_err;
  logic        req_valid;
  logic [7:0]  req_tag;
  logic        req_ready;
  logic        mem_grant;
  logic [4:0]  mem_slot;
  logic [7:0]  mem_tag;
  logic        done_valid;
  logic [4:0]  done_slot;
  logic [7:0]  done_tag;

  lookup_issue_ctrl i_lookup_issue_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_acc_cnt   (cfg_acc_cnt),
    .cfg_acc_pos   (cfg_acc_pos),
    .cfg_sched_len (cfg_sched_len),
    .cfg_err       (cfg_err),
    .req_valid     (req_valid),
    .req_tag       (req_tag),
    .req_ready     (req_ready),
    .mem_grant     (mem_grant),
    .mem_slot      (mem_slot),
    .mem_tag       (mem_tag),
    .done_valid    (done_valid),
    .done_slot     (done_slot),
    .done_tag      (done_tag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  // reference model state
  int adm_t   [32];
  bit adm_v   [32];
  int adm_tag [32];
  int pos_m   [4];
  int m_m;
  int len_m;
  int ptr_m;
  int acc_total;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_err();
    if (m_m < 1 || m_m > 4) return 1'b1;
    if (len_m < 1 || len_m > 32 * m_m) return 1'b1;
    for (int i = 0; i < m_m; i++) if (pos_m[i] >= len_m) return 1'b1;
    for (int i = 0; i < m_m; i++)
      for (int j = i + 1; j < m_m; j++)
        if (pos_m[i] % m_m == pos_m[j] % m_m) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit ctx_free(int s, int t);
    return !adm_v[s] || (t >= adm_t[s] + len_m);
  endfunction

  task automatic start_cfg(int m, int p0, int p1, int p2, int p3, int len);
    m_m = m; len_m = len;
    pos_m[0] = p0; pos_m[1] = p1; pos_m[2] = p2; pos_m[3] = p3;
    @(negedge clk);
    rst_n         = 1'b0;
    req_valid     = 1'b0;
    cfg_acc_cnt   = 3'(m);
    cfg_acc_pos   = {8'(p3), 8'(p2), 8'(p1), 8'(p0)};
    cfg_sched_len = 8'(len);
    repeat (2) @(negedge clk);
    #1;
    // R1
    chk("R1", "ready in reset", int'(req_ready), 0);
    chk("R1", "grant in reset", int'(mem_grant), 0);
    chk("R1", "done in reset", int'(done_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "ready before sync release", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 32; s++) adm_v[s] = 1'b0;
    ptr_m = 0;
    acc_total = 0;
    // R7
    chk("R7", "cfg_err", int'(cfg_err), int'(exp_err()));
  endtask

  task automatic run_cycles(int cycles, int vpct);
    bit err_e;
    err_e = exp_err();
    for (int t = 0; t < cycles; t++) begin
      bit v;
      bit rdy_e;
      int gs;
      int ds;
      v = ($urandom % 100) < vpct;
      req_valid = v;
      req_tag = 8'($urandom);
      #1;
      rdy_e = !err_e && (t % m_m == 0) && ctx_free(ptr_m, t);
      // R2 R8 R9
      chk("R2/R8/R9", $sformatf("ready t=%0d", t), int'(req_ready), int'(rdy_e));
      gs = -1;
      ds = -1;
      for (int s = 0; s < 32; s++) begin
        if (adm_v[s] && t >= adm_t[s] + 1 && t <= adm_t[s] + len_m) begin
          int e;
          e = t - adm_t[s] - 1;
          for (int i = 0; i < m_m && i < 4; i++)
            if (pos_m[i] == e && gs < 0) gs = s;
          if (e == len_m - 1 && ds < 0) ds = s;
        end
      end
      // R4
      chk("R4", $sformatf("grant t=%0d", t), int'(mem_grant), int'(gs >= 0));
      if (gs >= 0 && mem_grant) begin
        // R3
        chk("R3", "mem_slot", int'(mem_slot), gs);
        chk("R4", "mem_tag", int'(mem_tag), adm_tag[gs]);
      end
      // R5
      chk("R5", $sformatf("done t=%0d", t), int'(done_valid), int'(ds >= 0));
      if (ds >= 0 && done_valid) begin
        chk("R3", "done_slot", int'(done_slot), ds);
        chk("R5", "done_tag", int'(done_tag), adm_tag[ds]);
      end
      if (v && rdy_e) begin
        adm_v[ptr_m]   = 1'b1;
        adm_t[ptr_m]   = t;
        adm_tag[ptr_m] = int'(req_tag);
        ptr_m = (ptr_m + 1) % 32;
        acc_total++;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0102));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_tag = '0;
    cfg_acc_cnt = 3'd1;
    cfg_acc_pos = '0;
    cfg_sched_len = 8'd1;

    // R4: m=3 schedule at 0,2,7 with requests held high, then sparse
    start_cfg(3, 0, 2, 7, 200, 10);
    run_cycles(200, 100);
    start_cfg(3, 0, 2, 7, 200, 10);
    run_cycles(200, 40);
    // R9: longest legal schedules keep full rate
    start_cfg(3, 0, 2, 7, 0, 96);
    run_cycles(400, 100);
    chk("R9", "accepts at L=96 m=3", acc_total, 134);
    start_cfg(1, 5, 0, 0, 0, 32);
    run_cycles(200, 100);
    chk("R9", "accepts at L=32 m=1", acc_total, 200);
    start_cfg(4, 1, 6, 11, 0, 20);
    run_cycles(200, 70);
    // R7 R8: illegal schedules
    start_cfg(2, 0, 4, 0, 0, 8);
    run_cycles(30, 100);
    chk("R8", "accepts on dup residue", acc_total, 0);
    start_cfg(3, 0, 2, 7, 0, 97);
    run_cycles(20, 100);
    start_cfg(2, 0, 9, 0, 0, 9);
    run_cycles(20, 100);
    start_cfg(0, 0, 0, 0, 0, 9);
    chk("R7", "m=0 err", int'(cfg_err), 1);
    start_cfg(5, 0, 1, 2, 3, 9);
    chk("R7", "m=5 err", int'(cfg_err), 1);
    start_cfg(2, 0, 1, 0, 0, 0);
    chk("R7", "len=0 err", int'(cfg_err), 1);
    // R7: inactive fields would clash but are ignored
    start_cfg(2, 0, 3, 0, 1, 5);
    chk("R7", "inactive ignored", int'(cfg_err), 0);
    run_cycles(60, 100);

    // random schedules, some made illegal
    for (int r = 0; r < 24; r++) begin
      int m;
      int p[4];
      int mx;
      int len;
      int sel;
      m = 1 + ($urandom % 4);
      mx = 0;
      for (int i = 0; i < 4; i++) begin
        p[i] = (i < m) ? (i + m * int'($urandom % 8)) : int'($urandom % 256);
        if (i < m && p[i] > mx) mx = p[i];
      end
      len = mx + 1 + int'($urandom % 12);
      if (len > 32 * m) len = 32 * m;
      sel = $urandom % 8;
      if (sel == 0 && m >= 2) p[1] = p[0] + m;
      if (sel == 1) len = 32 * m + 1;
      if (sel == 2) len = mx;
      start_cfg(m, p[0], p[1], p[2], p[3], len);
      run_cycles(150 + int'($urandom % 150), 30 + int'($urandom % 71));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule